// File: doc/BRIEF.md
# Shared-Bus Flash and SRAM Select Arbiter

This block connects one host memory port to two memory devices that share a 16-bit data bus and the low address lines. One device is a flash with a single active-low chip enable. The other is an SRAM with two chip enables of opposite polarity. Each host request carries a target-select bit. The block routes the request to that device, drives the device's chip enable, output enable and write enable for a fixed number of clocks, and holds the other device deselected.

The two devices must never drive the shared bus together. Access windows therefore never overlap, and every window is followed by at least one clock in which both devices are deselected. When the next request goes to the other device, the block adds a parameterised number of extra turnaround clocks. The flash also has its own active-low reset. The block holds that reset low during its own reset and for a set number of clocks after it. It accepts no request until the flash reset has been released.

Top module: `membus_select`

## Requirements
- R1: At no clock are `flash_ce_n` low, `sram_ce1_n` low and `sram_ce2` high all at once.
- R2: A flash access (`req_sel`=0) drives `flash_ce_n` low for `ACC_CYC` consecutive clocks. During those clocks `flash_oe_n` is low for a read (`req_wr`=0) and `flash_we_n` is low for a write (`req_wr`=1), and the SRAM stays deselected.
- R3: While `rst_n` is low, all of the following hold: `flash_ce_n`, `flash_oe_n`, `flash_we_n`, `sram_ce1_n`, `sram_oe_n` and `sram_we_n` are high; `sram_ce2`, `bus_dout_en`, `req_ready`, `rsp_valid` and `flash_rst_n` are low; `flash_addr_hi` is zero.
- R4: An access to the device that served the previous request, or the first access after reset, starts on the clock after acceptance. An access to the other device starts `TURN_CYC`+1 clocks after acceptance. No clock has one device enabled when the other device was enabled on the clock before.
- R5: An SRAM access (`req_sel`=1) drives `sram_ce1_n` low and `sram_ce2` high for `ACC_CYC` clocks, with `sram_oe_n` low for a read and `sram_we_n` low for a write, while `flash_ce_n` stays high.
- R6: During an access, `mem_addr` carries request address bits 17:0. `flash_addr_hi` carries bits 20:18 only during a flash access and is zero at all other times, including SRAM accesses to high addresses.
- R7: After a read, `rsp_valid` is high for exactly one clock, on the clock after the last access clock. `rsp_rdata` then holds the value `bus_din` had on that last access clock. A write asserts `bus_dout_en` with the request data on `bus_dout` for the whole access and gives no response.
- R8: `flash_rst_n` goes high after `RST_HOLD` rising edges with `rst_n` high. Before that, `req_ready` is low and neither device is enabled.
- R9: `req_ready` is high only when the block is idle. A request whose `req_valid` is held through busy clocks is accepted exactly once, when `req_ready` is next high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_sel | input | 1 | Target device: 0 flash, 1 SRAM |
| req_wr | input | 1 | 1 write, 0 read |
| req_addr | input | 21 | Request address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| flash_rst_n | output | 1 | Flash reset, active low |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_addr_hi | output | 3 | Flash-only address bits 20:18 |
| sram_ce1_n | output | 1 | SRAM chip enable, active low |
| sram_ce2 | output | 1 | SRAM chip enable, active high |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| mem_addr | output | 18 | Shared address bits 17:0 |
| bus_dout | output | 16 | Data the block drives onto the shared bus |
| bus_dout_en | output | 1 | Block drives the shared bus |
| bus_din | input | 16 | Data read from the shared bus |

## Verification
Two events can fall on the same clock: the read response of one access, and the acceptance of the next request. This happens because the response pulse appears in the idle clock where `req_ready` is high again. The bench provokes it by holding `req_valid` high through busy periods and issuing back-to-back reads that alternate targets. A behavioural model then checks every clock that the response data is still correct, and that the new access start still waits out the owner-switch delay.

// File: rtl/msel_pkg.sv
package msel_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_TURN = 2'd1,
      PH_ACC  = 2'd2
   } phase_t;

   typedef enum logic {
      DEV_FLASH = 1'b0,
      DEV_SRAM  = 1'b1
   } dev_t;
endpackage

// File: rtl/msel_rst_hold.sv
module msel_rst_hold #(
   parameter int HOLD = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic frst_n
);
   localparam int CW = $clog2(HOLD + 1);

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("HOLD must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         frst_n <= 1'b0;
      end else if (!frst_n) begin
         if (cnt == CW'(HOLD - 1)) frst_n <= 1'b1;
         else                      cnt    <= cnt + 1'b1;
      end
   end

   // R8: once released, the flash reset stays released
   a_r8_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      frst_n |=> frst_n);
endmodule

// File: rtl/msel_sequencer.sv
module msel_sequencer
   import msel_pkg::*;
#(
   parameter int ADDR_W   = 21,
   parameter int DATA_W   = 16,
   parameter int ACC_CYC  = 2,
   parameter int TURN_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_sel,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] bus_din,
   output phase_t            ph,
   output dev_t              cur_sel,
   output logic              cur_wr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0] cur_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   localparam int MAX_C = (ACC_CYC > TURN_CYC) ? ACC_CYC : TURN_CYC;
   localparam int CNT_W = $clog2(MAX_C + 1);

   generate
      if (ACC_CYC < 1) begin : g_bad_acc
         $error("ACC_CYC must be at least 1");
      end
      if (TURN_CYC < 1) begin : g_bad_turn
         $error("TURN_CYC must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             own_vld;
   dev_t             own;
   logic             accept;

   assign req_ready = (ph == PH_IDLE) && frst_n;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         cnt       <= '0;
         cur_sel   <= DEV_FLASH;
         cur_wr    <= 1'b0;
         cur_addr  <= '0;
         cur_wdata <= '0;
         own_vld   <= 1'b0;
         own       <= DEV_FLASH;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (ph)
            PH_IDLE: begin
               if (accept) begin
                  cur_sel   <= dev_t'(req_sel);
                  cur_wr    <= req_wr;
                  cur_addr  <= req_addr;
                  cur_wdata <= req_wdata;
                  if (own_vld && (own != dev_t'(req_sel))) begin
                     ph  <= PH_TURN;
                     cnt <= CNT_W'(TURN_CYC - 1);
                  end else begin
                     ph  <= PH_ACC;
                     cnt <= CNT_W'(ACC_CYC - 1);
                  end
               end
            end
            PH_TURN: begin
               if (cnt == '0) begin
                  ph  <= PH_ACC;
                  cnt <= CNT_W'(ACC_CYC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_ACC: begin
               if (cnt == '0) begin
                  ph      <= PH_IDLE;
                  own     <= cur_sel;
                  own_vld <= 1'b1;
                  if (!cur_wr) begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= bus_din;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   // R7: a read response lasts exactly one clock
   a_r7_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R9: an accepted request moves the block out of idle on the next clock
   a_r9_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (ph != PH_IDLE));
endmodule

// File: rtl/msel_pins.sv
module msel_pins
   import msel_pkg::*;
#(
   parameter int ADDR_W       = 21,
   parameter int SHARED_W     = 18,
   parameter int DATA_W       = 16,
   parameter bit SRAM_IDLE_PD = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  phase_t                     ph,
   input  dev_t                       cur_sel,
   input  logic                       cur_wr,
   input  logic [ADDR_W-1:0]          cur_addr,
   input  logic [DATA_W-1:0]          cur_wdata,
   output logic                       flash_ce_n,
   output logic                       flash_oe_n,
   output logic                       flash_we_n,
   output logic [ADDR_W-SHARED_W-1:0] flash_addr_hi,
   output logic                       sram_ce1_n,
   output logic                       sram_ce2,
   output logic                       sram_oe_n,
   output logic                       sram_we_n,
   output logic [SHARED_W-1:0]        mem_addr,
   output logic [DATA_W-1:0]          bus_dout,
   output logic                       bus_dout_en
);
   localparam int HI_W = ADDR_W - SHARED_W;

   generate
      if (HI_W < 1) begin : g_bad_split
         $error("ADDR_W must exceed SHARED_W");
      end
   endgenerate

   logic act_f, act_s;

   assign act_f = (ph == PH_ACC) && (cur_sel == DEV_FLASH);
   assign act_s = (ph == PH_ACC) && (cur_sel == DEV_SRAM);

   assign flash_ce_n    = !act_f;
   assign flash_oe_n    = !(act_f && !cur_wr);
   assign flash_we_n    = !(act_f && cur_wr);
   assign flash_addr_hi = act_f ? cur_addr[ADDR_W-1:SHARED_W] : '0;

   assign sram_ce1_n = !act_s;
   assign sram_oe_n  = !(act_s && !cur_wr);
   assign sram_we_n  = !(act_s && cur_wr);

   generate
      if (SRAM_IDLE_PD) begin : g_sram_pd
         assign sram_ce2 = act_s;
      end else begin : g_sram_sb
         assign sram_ce2 = 1'b1;
      end
   endgenerate

   assign mem_addr    = cur_addr[SHARED_W-1:0];
   assign bus_dout    = cur_wdata;
   assign bus_dout_en = (act_f || act_s) && cur_wr;

   logic fl_on, sr_on;
   assign fl_on = !flash_ce_n;
   assign sr_on = !sram_ce1_n && sram_ce2;

   // R1: flash and SRAM never selected together
   a_r1_no_dual_select: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_on && sr_on));

   // R4: no direct hand-over from one device to the other
   a_r4_gap_to_sram: assert property (@(posedge clk) disable iff (!rst_n)
      sr_on |-> !$past(fl_on));
   a_r4_gap_to_flash: assert property (@(posedge clk) disable iff (!rst_n)
      fl_on |-> !$past(sr_on));

   // R5: SRAM output enable only while the flash is deselected
   a_r5_sram_oe_flash_off: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> flash_ce_n);

   // R2: flash output enable only while the SRAM is deselected
   a_r2_flash_oe_sram_off: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_oe_n |-> !sr_on);
endmodule

// File: rtl/membus_select.sv
module membus_select
   import msel_pkg::*;
#(
   parameter int ADDR_W       = 21,
   parameter int SHARED_W     = 18,
   parameter int DATA_W       = 16,
   parameter int ACC_CYC      = 2,
   parameter int TURN_CYC     = 1,
   parameter int RST_HOLD     = 4,
   parameter bit SRAM_IDLE_PD = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic                       req_sel,
   input  logic                       req_wr,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [DATA_W-1:0]          req_wdata,
   output logic                       rsp_valid,
   output logic [DATA_W-1:0]          rsp_rdata,
   output logic                       flash_rst_n,
   output logic                       flash_ce_n,
   output logic                       flash_oe_n,
   output logic                       flash_we_n,
   output logic [ADDR_W-SHARED_W-1:0] flash_addr_hi,
   output logic                       sram_ce1_n,
   output logic                       sram_ce2,
   output logic                       sram_oe_n,
   output logic                       sram_we_n,
   output logic [SHARED_W-1:0]        mem_addr,
   output logic [DATA_W-1:0]          bus_dout,
   output logic                       bus_dout_en,
   input  logic [DATA_W-1:0]          bus_din
);
   phase_t            ph;
   dev_t              cur_sel;
   logic              cur_wr;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_wdata;

   msel_rst_hold #(.HOLD(RST_HOLD)) u_rst_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .frst_n (flash_rst_n)
   );

   msel_sequencer #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .ACC_CYC  (ACC_CYC),
      .TURN_CYC (TURN_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .frst_n    (flash_rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_sel   (req_sel),
      .req_wr    (req_wr),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .bus_din   (bus_din),
      .ph        (ph),
      .cur_sel   (cur_sel),
      .cur_wr    (cur_wr),
      .cur_addr  (cur_addr),
      .cur_wdata (cur_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   msel_pins #(
      .ADDR_W       (ADDR_W),
      .SHARED_W     (SHARED_W),
      .DATA_W       (DATA_W),
      .SRAM_IDLE_PD (SRAM_IDLE_PD)
   ) u_pins (
      .clk           (clk),
      .rst_n         (rst_n),
      .ph            (ph),
      .cur_sel       (cur_sel),
      .cur_wr        (cur_wr),
      .cur_addr      (cur_addr),
      .cur_wdata     (cur_wdata),
      .flash_ce_n    (flash_ce_n),
      .flash_oe_n    (flash_oe_n),
      .flash_we_n    (flash_we_n),
      .flash_addr_hi (flash_addr_hi),
      .sram_ce1_n    (sram_ce1_n),
      .sram_ce2      (sram_ce2),
      .sram_oe_n     (sram_oe_n),
      .sram_we_n     (sram_we_n),
      .mem_addr      (mem_addr),
      .bus_dout      (bus_dout),
      .bus_dout_en   (bus_dout_en)
   );

   // R8: neither device is enabled while the flash is held in reset
   a_r8_no_access_in_frst: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_rst_n |-> (flash_ce_n && sram_ce1_n && !req_ready));
endmodule

// File: tb/membus_select_bench.sv
module membus_select_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ACC  = 2;
   localparam int TURN = 1;
   localparam int HOLD = 4;
   localparam int NREQ = 60;
   localparam int MAXCYC = 5000;

   logic        clk, rst_n;
   logic        req_valid, req_ready, req_sel, req_wr;
   logic [20:0] req_addr;
   logic [15:0] req_wdata, rsp_rdata, bus_dout, bus_din;
   logic        rsp_valid, flash_rst_n, flash_ce_n, flash_oe_n, flash_we_n;
   logic [2:0]  flash_addr_hi;
   logic        sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, bus_dout_en;
   logic [17:0] mem_addr;

   membus_select u_membus_select (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_sel(req_sel), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .flash_rst_n(flash_rst_n),
      .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
      .flash_addr_hi(flash_addr_hi), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
      .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .mem_addr(mem_addr),
      .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   logic        q_sel [NREQ];
   logic        q_wr  [NREQ];
   logic [20:0] q_addr[NREQ];
   logic [15:0] q_wd  [NREQ];

   // model state
   int          m_edges, m_ph, m_left, m_own, idx, gapcnt, acc_cyc, exp_lat, tail, prev_dev;
   logic        m_sel, m_wr, m_rspv;
   logic [20:0] m_addr;
   logic [15:0] m_wd, m_rspd;

   initial begin
      logic e_frst, e_ready, af, as_, acc, forb, done;
      int   cur_dev;
      rst_n = 1'b0; req_valid = 1'b0; req_sel = 1'b0; req_wr = 1'b0;
      req_addr = '0; req_wdata = '0; bus_din = '0;
      // directed requests: sel 0 flash / 1 sram, wr 1 write
      q_sel[0] = 0; q_wr[0] = 0; q_addr[0] = 21'h1A5A5A; q_wd[0] = 16'h0;
      q_sel[1] = 0; q_wr[1] = 0; q_addr[1] = 21'h000123; q_wd[1] = 16'h0;
      q_sel[2] = 1; q_wr[2] = 1; q_addr[2] = 21'h1C0042; q_wd[2] = 16'hBEEF;
      q_sel[3] = 1; q_wr[3] = 0; q_addr[3] = 21'h1C0042; q_wd[3] = 16'h0;
      q_sel[4] = 0; q_wr[4] = 1; q_addr[4] = 21'h1FFFFF; q_wd[4] = 16'h1234;
      q_sel[5] = 1; q_wr[5] = 0; q_addr[5] = 21'h000000; q_wd[5] = 16'h0;
      for (int i = 6; i < NREQ; i++) begin
         q_sel[i]  = 1'($urandom_range(0, 1));
         q_wr[i]   = 1'($urandom_range(0, 1));
         q_addr[i] = 21'($urandom);
         q_wd[i]   = 16'($urandom);
      end
      m_edges = 0; m_ph = 0; m_left = 0; m_own = -1; idx = 0; gapcnt = 0;
      m_sel = 0; m_wr = 0; m_addr = '0; m_wd = '0; m_rspv = 0; m_rspd = '0;
      acc_cyc = 0; exp_lat = 1; tail = 0; prev_dev = -1; done = 1'b0;

      for (int cyc = 0; cyc < MAXCYC && !done; cyc++) begin
         @(negedge clk);
         // expected outputs from the model
         e_frst  = (m_edges >= HOLD);
         e_ready = (m_ph == 0) && e_frst;
         af  = (m_ph == 2) && !m_sel;
         as_ = (m_ph == 2) && m_sel;
         if (cyc < 3) begin
            // R3: reset state
            chk("R3", {flash_ce_n, flash_oe_n, flash_we_n, sram_ce1_n, sram_oe_n, sram_we_n},
                6'b111111);
            chk("R3", {sram_ce2, bus_dout_en, req_ready, rsp_valid, flash_rst_n, flash_addr_hi},
                8'b0);
         end else begin
            chk("R8", flash_rst_n, e_frst);
            chk("R9", req_ready, e_ready);
            chk("R2", {flash_ce_n, flash_oe_n, flash_we_n},
                {!af, !(af && !m_wr), !(af && m_wr)});
            chk("R5", {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n},
                {!as_, as_, !(as_ && !m_wr), !(as_ && m_wr)});
            chk("R6", flash_addr_hi, af ? m_addr[20:18] : 3'b0);
            if (af || as_) chk("R6", mem_addr, m_addr[17:0]);
            chk("R7", bus_dout_en, (af || as_) && m_wr);
            if ((af || as_) && m_wr) chk("R7", bus_dout, m_wd);
            chk("R7", rsp_valid, m_rspv);
            if (m_rspv) chk("R7", rsp_rdata, m_rspd);
         end
         forb = !flash_ce_n && !sram_ce1_n && sram_ce2;
         chk("R1", forb, 1'b0);
         cur_dev = !flash_ce_n ? 0 : ((!sram_ce1_n && sram_ce2) ? 1 : -1);
         if (cur_dev >= 0 && prev_dev >= 0 && cur_dev != prev_dev)
            chk("R4", 1, 0);
         if (cur_dev >= 0 && prev_dev < 0)
            chk("R4", cyc - acc_cyc, exp_lat);
         prev_dev = cur_dev;

         // drive inputs for this clock
         rst_n   = (cyc >= 2);
         bus_din = 16'($urandom);
         if (idx < NREQ && gapcnt == 0) begin
            req_valid = 1'b1; req_sel = q_sel[idx]; req_wr = q_wr[idx];
            req_addr = q_addr[idx]; req_wdata = q_wd[idx];
         end else begin
            req_valid = 1'b0; req_sel = 1'($urandom_range(0, 1));
            req_wr = 1'($urandom_range(0, 1));
            req_addr = 21'($urandom); req_wdata = 16'($urandom);
         end

         // advance model to the state after the coming edge
         m_rspv = 1'b0;
         if (!rst_n) begin
            m_edges = 0; m_ph = 0; m_own = -1;
         end else begin
            acc = req_valid && e_ready;
            if (m_edges < HOLD) m_edges++;
            case (m_ph)
               0: if (acc) begin
                  m_sel = req_sel; m_wr = req_wr; m_addr = req_addr; m_wd = req_wdata;
                  acc_cyc = cyc;
                  if (m_own >= 0 && m_own != int'(req_sel)) begin
                     m_ph = 1; m_left = TURN; exp_lat = 1 + TURN;
                  end else begin
                     m_ph = 2; m_left = ACC; exp_lat = 1;
                  end
                  idx++;
                  gapcnt = (idx < 6) ? 0 : $urandom_range(0, 2);
               end else if (!req_valid && gapcnt > 0) begin
                  gapcnt--;
               end
               1: begin
                  m_left--;
                  if (m_left == 0) begin m_ph = 2; m_left = ACC; end
               end
               default: begin
                  m_left--;
                  if (m_left == 0) begin
                     m_ph = 0; m_own = int'(m_sel);
                     if (!m_wr) begin m_rspv = 1'b1; m_rspd = bus_din; end
                  end
               end
            endcase
            if (m_ph != 0 && !req_valid && gapcnt > 0) gapcnt--;
         end
         if (idx == NREQ && m_ph == 0) tail++;
         if (tail > 3) done = 1'b1;
      end
      if (!done) begin
         fails++;
         $display("FAIL R9 watchdog actual=%0d expected=%0d", idx, NREQ);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule